// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block is the central arbiter of a shared parallel bus. It serves six requesters: the bridge's own master (index 0) and five external masters. Each one has a request wire and a grant wire. A small control register places every requester in a high or a low priority group and carries a global enable. The high-priority requesters take turns in a round robin. The whole low-priority group fills one extra slot of that round robin and takes turns inside the group. This way every high requester and, over enough rotations, every low requester is served.

The next winner is computed all the time from the live requests. It is loaded into the grant register only on a transfer-complete pulse or while the bus is idle, so arbitration overlaps the current access and costs no bus cycles. While reset is asserted, a strap input sets the power-up value of the enable. The controller has three states:
- `ST_OFF`: the arbiter is disabled and no grant is driven.
- `ST_PARK`: the grant rests on the bridge because nobody asked.
- `ST_BUSY`: the grant is held by a requester that asked for it.

The transitions are:
- OFF→PARK when the arbiter becomes enabled.
- PARK/BUSY→OFF when it is disabled.
- PARK/BUSY→BUSY on an update that finds a request.
- PARK/BUSY→PARK on an update that finds no request.

Top module: `hier_rr_arbiter`

## Requirements
- R1: At most one bit of `gnt` is set in any cycle. `gnt[i]` grants requester i, and requester 0 is the bridge's own master.
- R2: A write through `cfg_wr` loads `cfg_wdata`, which takes effect in the cycle after the write. Bit i of `cfg_wdata[5:0]` set to 1 puts requester i in the high group, and 0 puts it in the low group.
- R3: The high round robin has slots 0..5, one per requester, and slot 6, which stands for the low group. A slot is eligible when its requester is high and requesting (slot 6: any low requester is requesting). The search starts at the slot after the last high-round-robin winner and moves upward with wrap-around. After reset the search starts at slot 0.
- R4: The low group takes turns inside slot 6, searching upward from the requester after the last low winner. The low pointer moves only when slot 6 wins, so every low requester is served within M low turns.
- R5: `gnt` changes only in the cycle after `xfer_done` or `bus_idle` is high, apart from enable changes (R6, R8).
- R6: `cfg_wdata[15]` = 1 enables the arbiter and 0 disables it.
- R7: While `rst_n` is low, `strap_arb_off` is sampled into the enable: low means enabled and high means disabled.
- R8: When the arbiter is disabled, `gnt` is all zero in the next cycle and both rotation pointers hold. On re-enable, the first cycle parks the grant on requester 0.
- R9: An update that finds no request at all parks the grant on requester 0.
- R10: During reset, `gnt` is zero, all requesters are high, and both pointers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_arb_off | input | 1 | Reset strap, high disables the arbiter |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control word: [15] enable, [5:0] high-group bits |
| req | input | 6 | Request per requester |
| xfer_done | input | 1 | Current transfer completes this cycle |
| bus_idle | input | 1 | Bus has no transfer in progress |
| gnt | output | 6 | One-hot grant per requester |

## Verification
The bench builds the block with its default parameters: six requesters, the bridge at index 0, and the enable at bit 15. With six requesters, a 2-high/4-low split is possible. That split walks the low pointer through its full wrap, from requester 5 back to 2. It also shows the low pointer staying put while high requesters win. The same size lets the strap be tried at both levels across separate resets, and lets a disable/re-enable cycle show that the high pointer holds its value.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PARK = 2'd1,
        ST_BUSY = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_cfg_reg.sv
`timescale 1ns/1ps
module arb_cfg_reg #(
    parameter int N      = 6,
    parameter int CFG_W  = 16,
    parameter int EN_BIT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_arb_off,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             arb_en,
    output logic [N-1:0]     high_grp
);
    // Strap is captured on every clock while reset is held (R7)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_en   <= ~strap_arb_off;
            high_grp <= '1;
        end else if (cfg_wr) begin
            arb_en   <= cfg_wdata[EN_BIT];
            high_grp <= cfg_wdata[N-1:0];
        end
    end
endmodule

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
module rr_pick #(
    parameter int N  = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] ptr,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int off = 0; off < N; off++) begin
            if (!any && vec[(int'(ptr) + off) % N]) begin
                any = 1'b1;
                idx = IW'((int'(ptr) + off) % N);
            end
        end
    end
endmodule

// File: rtl/hier_rr_arbiter.sv
`timescale 1ns/1ps
module hier_rr_arbiter #(
    parameter int N        = 6,
    parameter int SELF_IDX = 0,
    parameter int CFG_W    = 16,
    parameter int EN_BIT   = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_arb_off,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [N-1:0]     req,
    input  logic             xfer_done,
    input  logic             bus_idle,
    output logic [N-1:0]     gnt
);
    import arb_pkg::*;

    localparam int SLOTS = N + 1;
    localparam int HPW   = $clog2(SLOTS);
    localparam int LPW   = $clog2(N);

    logic             arb_en;
    logic [N-1:0]     high_grp;
    logic [N-1:0]     low_vec;
    logic [SLOTS-1:0] slot_vec;
    logic             hi_any, lo_any, upd;
    logic [HPW-1:0]   hi_idx, hp, hp_nx;
    logic [LPW-1:0]   lo_idx, lp, lp_nx, gidx, gidx_nx, win_idx;
    arb_state_e       state, state_nx;

    arb_cfg_reg #(.N(N), .CFG_W(CFG_W), .EN_BIT(EN_BIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .strap_arb_off(strap_arb_off),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .arb_en(arb_en), .high_grp(high_grp)
    );

    assign low_vec = req & ~high_grp;

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign slot_vec[i] = req[i] & high_grp[i];
    end
    assign slot_vec[N] = |low_vec;

    rr_pick #(.N(SLOTS)) u_hi (.vec(slot_vec), .ptr(hp), .any(hi_any), .idx(hi_idx));
    rr_pick #(.N(N))     u_lo (.vec(low_vec),  .ptr(lp), .any(lo_any), .idx(lo_idx));

    assign upd     = xfer_done | bus_idle;
    assign win_idx = (hi_idx == HPW'(N)) ? lo_idx : hi_idx[LPW-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            gidx  <= LPW'(SELF_IDX);
            hp    <= '0;
            lp    <= '0;
        end else begin
            state <= state_nx;
            gidx  <= gidx_nx;
            hp    <= hp_nx;
            lp    <= lp_nx;
        end
    end

    // Next-state and pointer logic
    always_comb begin
        state_nx = state;
        gidx_nx  = gidx;
        hp_nx    = hp;
        lp_nx    = lp;
        unique case (state)
            ST_OFF: begin
                if (arb_en) begin
                    state_nx = ST_PARK;
                    gidx_nx  = LPW'(SELF_IDX);
                end
            end
            ST_PARK, ST_BUSY: begin
                if (!arb_en) begin
                    state_nx = ST_OFF;
                end else if (upd) begin
                    if (hi_any) begin
                        state_nx = ST_BUSY;
                        gidx_nx  = win_idx;
                        if (hi_idx == HPW'(N)) begin
                            hp_nx = '0;
                            if (lo_any)
                                lp_nx = (lo_idx == LPW'(N - 1)) ? '0 : lo_idx + LPW'(1);
                        end else begin
                            hp_nx = hi_idx + HPW'(1);
                        end
                    end else begin
                        state_nx = ST_PARK;
                        gidx_nx  = LPW'(SELF_IDX);
                    end
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        gnt = '0;
        if (state != ST_OFF)
            gnt[gidx] = 1'b1;
    end

    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && arb_en && !upd) |=> $stable(gnt));

    assert_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> (gnt == '0));

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !arb_en |=> ($stable(hp) && $stable(lp)));

    assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && arb_en && upd && req == '0) |=> (gnt == (N'(1) << SELF_IDX)));

    assert_winner_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_OFF && arb_en && upd && req != '0) |=> ((gnt & $past(req)) != '0));
endmodule

// File: tb/test_hier_rr_arbiter.sv
`timescale 1ns/1ps
module test_hier_rr_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_arb_off = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [5:0]  req = '0;
    logic        xfer_done = 1'b0;
    logic        bus_idle = 1'b0;
    logic [5:0]  gnt;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hier_rr_arbiter i_hier_rr_arbiter (
        .clk(clk), .rst_n(rst_n), .strap_arb_off(strap_arb_off),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .req(req),
        .xfer_done(xfer_done), .bus_idle(bus_idle), .gnt(gnt)
    );

    // {wr, wdata[15:0], req[5:0], done, idle, expected gnt[5:0], requirement number}
    localparam int NV = 29;
    localparam logic [34:0] VEC [0:NV-1] = '{
        {1'b0, 16'h0000, 6'b000000, 1'b0, 1'b0, 6'b000001, 4'd9}, // R9 OFF->PARK on bridge
        {1'b0, 16'h0000, 6'b000000, 1'b0, 1'b1, 6'b000001, 4'd9}, // R9 idle, no request
        {1'b0, 16'h0000, 6'b001010, 1'b0, 1'b1, 6'b000010, 4'd3}, // R3 from slot 0 -> 1
        {1'b0, 16'h0000, 6'b001010, 1'b0, 1'b0, 6'b000010, 4'd5}, // R5 no update, hold
        {1'b0, 16'h0000, 6'b001010, 1'b1, 1'b0, 6'b001000, 4'd3}, // R3 next is 3
        {1'b0, 16'h0000, 6'b001010, 1'b1, 1'b0, 6'b000010, 4'd3}, // R3 wrap to 1
        {1'b1, 16'h8003, 6'b000000, 1'b0, 1'b0, 6'b000010, 4'd5}, // R5 write only, hold
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b000100, 4'd4}, // R4 low slot, m2
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b000010, 4'd2}, // R2 m1 is high
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b001000, 4'd4}, // R4 low m3
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b000010, 4'd3},
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b010000, 4'd4}, // R4 low m4
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b000010, 4'd3},
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b100000, 4'd4}, // R4 low m5
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b000010, 4'd3},
        {1'b0, 16'h0000, 6'b111110, 1'b1, 1'b0, 6'b000100, 4'd4}, // R4 low wraps to m2
        {1'b0, 16'h0000, 6'b000010, 1'b1, 1'b0, 6'b000010, 4'd3}, // high win, lp stays
        {1'b0, 16'h0000, 6'b100110, 1'b1, 1'b0, 6'b100000, 4'd4}, // R4 lp held at 3 -> m5
        {1'b0, 16'h0000, 6'b000011, 1'b1, 1'b0, 6'b000001, 4'd1}, // R1 bridge as requester
        {1'b0, 16'h0000, 6'b000011, 1'b1, 1'b0, 6'b000010, 4'd3},
        {1'b1, 16'h0003, 6'b000011, 1'b0, 1'b0, 6'b000010, 4'd5}, // disable written
        {1'b0, 16'h0000, 6'b000011, 1'b1, 1'b0, 6'b000000, 4'd6}, // R6 disabled
        {1'b0, 16'h0000, 6'b000011, 1'b1, 1'b0, 6'b000000, 4'd8}, // R8 stays off
        {1'b1, 16'h8003, 6'b000011, 1'b1, 1'b0, 6'b000000, 4'd6}, // R6 enable written
        {1'b0, 16'h0000, 6'b000011, 1'b1, 1'b0, 6'b000001, 4'd8}, // R8 re-enable parks
        {1'b0, 16'h0000, 6'b000011, 1'b1, 1'b0, 6'b000001, 4'd8}, // R8 hp held at 2 -> slot 0
        {1'b0, 16'h0000, 6'b000011, 1'b1, 1'b0, 6'b000010, 4'd3},
        {1'b0, 16'h0000, 6'b000000, 1'b0, 1'b1, 6'b000001, 4'd9}, // R9 park
        {1'b0, 16'h0000, 6'b000100, 1'b0, 1'b0, 6'b000001, 4'd5}  // R5 no update
    };

    task automatic chk(input logic [5:0] exp, input int rq, input string what);
        n_chk++;
        if (gnt !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: gnt=%b expected=%b", rq, what, gnt, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired: gnt=%b expected=completion", gnt);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(6'b000000, 10, "R10 gnt zero in reset");
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            {cfg_wr, cfg_wdata, req, xfer_done, bus_idle} = VEC[v][34:10];
            @(posedge clk);
            #1;
            chk(VEC[v][9:4], int'(VEC[v][3:0]), $sformatf("vector %0d", v));
            @(negedge clk);
        end
        cfg_wr = 1'b0;

        // R7: strap high holds the arbiter off after reset
        rst_n = 1'b0;
        strap_arb_off = 1'b1;
        req = 6'b111111;
        bus_idle = 1'b1;
        xfer_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(6'b000000, 10, "R10 gnt zero in reset");
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            #1;
            chk(6'b000000, 7, "R7 strap high disables");
        end
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = 16'h803F;
        @(posedge clk);
        #1;
        chk(6'b000000, 6, "R6 enable takes effect next cycle");
        @(negedge clk);
        cfg_wr = 1'b0;
        @(posedge clk);
        #1;
        chk(6'b000001, 8, "R8 first enabled cycle parks");
        @(posedge clk);
        #1;
        chk(6'b000001, 10, "R10 pointer from 0 picks m0");
        @(posedge clk);
        #1;
        chk(6'b000010, 2, "R2 all high after reset, m1 next");
        @(negedge clk);
        strap_arb_off = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule